// File: doc/BRIEF.md
# Self-Starting Five-Code Sequence Counter

This block is a 3-bit counter that walks a fixed, non-binary loop of five codes. It takes one step on each clock edge where the enable is high. The state bits are ordered C (most significant), B, A. The loop uses codes 000, 010, 011, 101 and 110, and it returns to 000 after 110.

The three codes outside the loop are 001, 100 and 111. Each of them still has a fixed successor, so the register can never stay stuck in an unused code. This matters at power-up, when the flip-flops may hold any value. From any starting code the counter is back in the loop within two enabled steps, and it then follows the normal order.

A synchronous, active-high reset loads 000. The block also drives a combinational flag that is high whenever the present code belongs to the loop. A parameter selects how the next state is built: closed-form D-input equations, or a per-code lookup. Both forms give the same result.

Top module: `seq5_counter`

## Requirements
- R1: When reset is high at a clock edge, the state becomes 000 on that edge and the valid flag reads 1.
- R2: With enable high, the loop codes step in this order: 000 to 010, 010 to 011, 011 to 101, 101 to 110, and 110 back to 000.
- R3: With enable low and reset low, a clock edge leaves the state unchanged.
- R4: With enable high, unused code 001 steps to 110.
- R5: With enable high, unused code 100 steps to 010.
- R6: With enable high, unused code 111 steps to 100.
- R7: The valid flag is 1 exactly for the codes 000, 010, 011, 101 and 110. It is 0 for 001, 100 and 111.
- R8: From any of the eight starting codes, the valid flag is 1 after at most two enabled steps. Every later enabled step then follows the R2 order.
- R9: Reset takes priority over enable. With both high at an edge, the state becomes 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the state updates on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high; loads 000 |
| en_i | input | 1 | Count enable; when high the counter takes one step per edge |
| state_o | output | 3 | Present code, with bit 2 = C, bit 1 = B and bit 0 = A |
| valid_o | output | 1 | High when state_o is one of the five loop codes |

## Verification
Reset and enable can both be high at the same edge. The bench provokes this by raising both in the middle of a run, and it expects the state to be 000 afterwards, because reset wins.

A recovery step from an unused code can also be followed directly by a normal loop step. The bench sets each of the eight codes as the starting state while reset is held, releases reset, and then enables counting. It compares every code reached, and the valid flag, against a bench model that holds the five-code order and the three recovery paths.

// File: rtl/seq5_pkg.sv
package seq5_pkg;

   localparam int CODE_W    = 3;
   localparam int LOOP_LEN  = 5;
   localparam int NUM_CODES = 1 << CODE_W;

   typedef logic [CODE_W-1:0] code_t;

   // Codes on the main loop, in stepping order.
   localparam code_t LOOP_0 = 3'b000;
   localparam code_t LOOP_1 = 3'b010;
   localparam code_t LOOP_2 = 3'b011;
   localparam code_t LOOP_3 = 3'b101;
   localparam code_t LOOP_4 = 3'b110;

   // Codes left off the loop.
   localparam code_t SPARE_0 = 3'b001;
   localparam code_t SPARE_1 = 3'b100;
   localparam code_t SPARE_2 = 3'b111;

   // Next-state construction variants.
   localparam int STYLE_EQN   = 0;
   localparam int STYLE_TABLE = 1;

   // Bit positions of the named state bits.
   localparam int BIT_A = 0;
   localparam int BIT_B = 1;
   localparam int BIT_C = 2;

endpackage

// File: rtl/seq5_next.sv
module seq5_next
   import seq5_pkg::*;
#(
   parameter int STYLE = STYLE_EQN
) (
   input  code_t cur_i,
   output code_t nxt_o
);

   generate
      if (STYLE == STYLE_EQN) begin : g_eqn
         logic a_w, b_w, c_w;
         assign a_w = cur_i[BIT_A];
         assign b_w = cur_i[BIT_B];
         assign c_w = cur_i[BIT_C];
         // Closed-form D inputs chosen so that every spare code re-enters the loop.
         assign nxt_o[BIT_C] = a_w;
         assign nxt_o[BIT_B] = ~b_w | (~a_w & ~c_w);
         assign nxt_o[BIT_A] = b_w & ~c_w;
      end else if (STYLE == STYLE_TABLE) begin : g_table
         always_comb begin
            unique case (cur_i)
               LOOP_0:  nxt_o = LOOP_1;
               LOOP_1:  nxt_o = LOOP_2;
               LOOP_2:  nxt_o = LOOP_3;
               LOOP_3:  nxt_o = LOOP_4;
               LOOP_4:  nxt_o = LOOP_0;
               SPARE_0: nxt_o = LOOP_4;
               SPARE_1: nxt_o = LOOP_1;
               SPARE_2: nxt_o = SPARE_1;
               default: nxt_o = LOOP_0;
            endcase
         end
      end else begin : g_bad_style
         initial $error("seq5_next: STYLE must be STYLE_EQN or STYLE_TABLE");
         assign nxt_o = LOOP_0;
      end
   endgenerate

endmodule

// File: rtl/seq5_state_reg.sv
module seq5_state_reg #(
   parameter int              W       = 3,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         en_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] q_r;

   // Reset has priority over enable; enable low holds the value.
   always_ff @(posedge clk_i) begin
      if (rst_i)
         q_r <= RST_VAL;
      else if (en_i)
         q_r <= d_i;
   end

   assign q_o = q_r;

endmodule

// File: rtl/seq5_valid.sv
module seq5_valid
   import seq5_pkg::*;
#(
   parameter int STYLE = STYLE_EQN
) (
   input  code_t cur_i,
   output logic  valid_o
);

   generate
      if (STYLE == STYLE_EQN) begin : g_eqn
         // The spare codes are 001, 100 and 111, so flag those and invert.
         logic spare_w;
         assign spare_w = (~cur_i[BIT_B] & (cur_i[BIT_C] ^ cur_i[BIT_A]))
                        | (&cur_i);
         assign valid_o = ~spare_w;
      end else begin : g_table
         always_comb begin
            unique case (cur_i)
               LOOP_0, LOOP_1, LOOP_2, LOOP_3, LOOP_4: valid_o = 1'b1;
               default:                                valid_o = 1'b0;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/seq5_counter.sv
module seq5_counter
   import seq5_pkg::*;
#(
   parameter int STATE_W    = CODE_W,
   parameter int NEXT_STYLE = STYLE_EQN
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               en_i,
   output logic [STATE_W-1:0] state_o,
   output logic               valid_o
);

   localparam logic [STATE_W-1:0] RESET_CODE = '0;

   generate
      if (STATE_W != CODE_W) begin : g_bad_width
         initial $error("seq5_counter: STATE_W must equal CODE_W (3)");
      end
      if (NEXT_STYLE != STYLE_EQN && NEXT_STYLE != STYLE_TABLE) begin : g_bad_style
         initial $error("seq5_counter: unknown NEXT_STYLE");
      end
   endgenerate

   code_t cur_w;
   code_t nxt_w;

   seq5_next #(.STYLE(NEXT_STYLE)) u_next (
      .cur_i (cur_w),
      .nxt_o (nxt_w)
   );

   seq5_state_reg #(.W(CODE_W), .RST_VAL(RESET_CODE)) u_state (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .en_i  (en_i),
      .d_i   (nxt_w),
      .q_o   (cur_w)
   );

   seq5_valid #(.STYLE(NEXT_STYLE)) u_valid (
      .cur_i   (cur_w),
      .valid_o (valid_o)
   );

   assign state_o = cur_w;

endmodule

// File: rtl/seq5_counter_chk.sv
module seq5_counter_chk (
   input logic       clk_i,
   input logic       rst_i,
   input logic       en_i,
   input logic [2:0] state_o,
   input logic       valid_o
);

   function automatic logic [2:0] loop_succ(input logic [2:0] c);
      case (c)
         3'b000:  return 3'b010;
         3'b010:  return 3'b011;
         3'b011:  return 3'b101;
         3'b101:  return 3'b110;
         default: return 3'b000;
      endcase
   endfunction

   // R2
   loop_order_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!$past(rst_i) && $past(en_i) && $past(valid_o))
         |-> (state_o == loop_succ($past(state_o))));

   // R3
   hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!$past(rst_i) && !$past(en_i)) |-> $stable(state_o));

   // R4
   spare_001_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!$past(rst_i) && $past(en_i) && $past(state_o) == 3'b001)
         |-> (state_o == 3'b110));

   // R5
   spare_100_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!$past(rst_i) && $past(en_i) && $past(state_o) == 3'b100)
         |-> (state_o == 3'b010));

   // R6
   spare_111_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!$past(rst_i) && $past(en_i) && $past(state_o) == 3'b111)
         |-> (state_o == 3'b100));

   // R7
   valid_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      valid_o == !(state_o == 3'b001 || state_o == 3'b100 || state_o == 3'b111));

   // R8
   recover_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!$past(rst_i) && $past(en_i) && !$past(valid_o) && $past(state_o) != 3'b111)
         |-> valid_o);

endmodule

bind seq5_counter seq5_counter_chk u_chk (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .en_i    (en_i),
   .state_o (state_o),
   .valid_o (valid_o)
);

// File: tb/seq5_counter_test.sv
`timescale 1ns/1ps
module seq5_counter_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en  = 1'b0;
   logic [2:0] state;
   logic       valid;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;   // 250 MHz

   seq5_counter uut (
      .clk_i   (clk),
      .rst_i   (rst),
      .en_i    (en),
      .state_o (state),
      .valid_o (valid)
   );

   // Loop position of a code, or -1 for a spare code.
   function automatic int loop_pos(input logic [2:0] c);
      case (c)
         3'b000: return 0;
         3'b010: return 1;
         3'b011: return 2;
         3'b101: return 3;
         3'b110: return 4;
         default: return -1;
      endcase
   endfunction

   function automatic logic [2:0] loop_code(input int p);
      logic [2:0] tbl [5] = '{3'b000, 3'b010, 3'b011, 3'b101, 3'b110};
      return tbl[p % 5];
   endfunction

   function automatic logic [2:0] model_next(input logic [2:0] c);
      if (loop_pos(c) >= 0) return loop_code(loop_pos(c) + 1);
      if (c == 3'b001) return 3'b110;
      if (c == 3'b100) return 3'b010;
      return 3'b100;
   endfunction

   task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [2:0] exp_state;
      @(negedge clk);
      step();
      step();
      // R1
      check("R1 state", {1'b0, state}, 4'b0000);
      check("R1 valid", {3'b0, valid}, 4'b0001);

      // R2: twelve steps around the loop from 000
      rst = 1'b0;
      en  = 1'b1;
      exp_state = 3'b000;
      for (int i = 0; i < 12; i++) begin
         step();
         exp_state = model_next(exp_state);
         check("R2 loop order", {1'b0, state}, {1'b0, exp_state});
      end

      // R3: enable pattern 0,1,0,0,1,0
      for (int i = 0; i < 6; i++) begin
         en = (i == 1 || i == 4);
         step();
         if (en) exp_state = model_next(exp_state);
         check("R3 hold with enable low", {1'b0, state}, {1'b0, exp_state});
      end

      // Every one of the eight codes as a starting state
      for (int code = 0; code < 8; code++) begin
         int first_valid;
         rst = 1'b1;
         en  = 1'b0;
         force uut.u_state.q_r = code[2:0];
         step();
         // R7
         check("R7 valid flag", {3'b0, valid},
               {3'b0, (loop_pos(code[2:0]) >= 0)});
         rst = 1'b0;
         release uut.u_state.q_r;
         #0.5;
         check("R3 start code kept", {1'b0, state}, {1'b0, code[2:0]});
         en = 1'b1;
         exp_state = code[2:0];
         first_valid = (loop_pos(exp_state) >= 0) ? 0 : -1;
         for (int s = 1; s <= 8; s++) begin
            step();
            exp_state = model_next(exp_state);
            if (s == 1 && code == 1) check("R4 001 escape", {1'b0, state}, 4'b0110);
            if (s == 1 && code == 4) check("R5 100 escape", {1'b0, state}, 4'b0010);
            if (s == 1 && code == 7) check("R6 111 escape", {1'b0, state}, 4'b0100);
            check("R8 recovery path", {1'b0, state}, {1'b0, exp_state});
            check("R7 valid along path", {3'b0, valid},
                  {3'b0, (loop_pos(exp_state) >= 0)});
            if (first_valid < 0 && valid === 1'b1) first_valid = s;
         end
         // R8: loop reached within two enabled steps
         check("R8 steps to loop", first_valid[3:0],
               (first_valid >= 0 && first_valid <= 2) ? first_valid[3:0] : 4'd2);
      end

      // R9: reset and enable together mid-loop
      en = 1'b1;
      step();
      step();
      rst = 1'b1;
      step();
      check("R9 reset beats enable", {1'b0, state}, 4'b0000);
      rst = 1'b0;
      step();
      check("R9 count resumes", {1'b0, state}, 4'b0010);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule